// File: doc/BRIEF.md
# Stop-Mode Clock Sequencer

This block moves a microcontroller clock domain into and out of its deepest low-power state. It runs on an always-on control clock. A stop request from the core starts an ordered teardown that takes one control-clock cycle per step. The steps are: force the oscillator as clock source, turn off the PLL, gate the core clock, then gate the remaining system clocks. Only after the last step is the stop state declared, and only then is low-power requested from neighbouring units such as the voltage regulator. A wake-up event brings the clocks back in reverse order.

Two flavours of stop are supported, chosen by a select bit that is captured when the request is accepted:

- **Full stop** turns the oscillator off, silences every timer and cancels a running clock-quality check if the domain was in self-clock mode. A fresh full-window check is then started when the domain returns to run.
- **Pseudo stop** keeps the oscillator running. The periodic-interrupt timer and the watchdog keep their clocks when their keep-alive bits are set. When pseudo stop is entered from self-clock mode, the PLL and regulator stay up and quality checks repeat until one passes.

A free-running prescaler driven by the system clock enable models the dividers: it freezes in stop and resumes from its held phase. All pins are plain control and status; there is no streaming interface.

Top module: `stop_clk_seq`

## Requirements
- R1: A stop request accepted in run state clears the PLL-select output on the next cycle. The core, system and PLL enables are all still high in that cycle.
- R2: After the PLL-select clear, the PLL enable drops one cycle later, the core enable one cycle after that, and the system enable one cycle after that. The exception is pseudo stop from self-clock mode, where the PLL enable stays high.
- R3: The stop-active flag rises in the cycle after the system enable falls, and only then. While stop-active is high, the core and system enables are low.
- R4: While stopped, the oscillator enable is low in full stop and high in pseudo stop.
- R5: From the cycle the system clocks are gated until they return, the periodic-interrupt clock enable equals pseudo AND its keep-alive bit, and the watchdog clock enable equals pseudo AND its keep-alive bit. At all other times both are high.
- R6: The prescaler advances only while the system enable is high and is never reset by stop. As a result, every interval between two consecutive tick pulses contains exactly DIV cycles with the system enable high.
- R7: The regulator low-power request is high exactly while stopped, except in pseudo stop entered from self-clock mode, where it stays low.
- R8: In pseudo stop entered from self-clock mode, a check-start strobe is issued after acceptance, and another one after each reported check that failed (done with ok low). No further strobe follows a passing check.
- R9: In full stop entered from self-clock mode, a one-cycle check-abort strobe is issued in the cycle after acceptance. A one-cycle check-start strobe is issued in the first run cycle after wake-up.
- R10: A wake-up event while stopped drops stop-active and raises the oscillator enable on the next cycle. The system enable rises one cycle later, the core enable one cycle after that, and the PLL enable in the first run cycle. PLL-select stays low until set again.
- R11: A stop request outside run state and a wake-up event outside the stopped state have no effect on the sequence or the outputs.
- R12: After reset: all clock enables high, PLL-select low, stop-active, low-power request and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Stop request from the core |
| wake_evt | input | 1 | Wake-up event |
| pstop_sel | input | 1 | 1 selects pseudo stop, 0 full stop |
| rti_keep | input | 1 | Keep periodic-interrupt timer clock in pseudo stop |
| wdt_keep | input | 1 | Keep watchdog clock in pseudo stop |
| pll_sel_set | input | 1 | Software request to select the PLL clock (run state only) |
| scm_active | input | 1 | Domain is currently in self-clock mode |
| cqc_done | input | 1 | Clock-quality check finished (one-cycle pulse) |
| cqc_ok | input | 1 | Result qualifier for cqc_done: 1 passed |
| pll_sel | output | 1 | Effective PLL-select bit |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| sys_clk_en | output | 1 | System clock gate enable |
| rti_clk_en | output | 1 | Periodic-interrupt timer clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| vreg_lp_req | output | 1 | Low-power request to regulator and other units |
| cqc_start | output | 1 | Clock-quality check start strobe |
| cqc_abort | output | 1 | Clock-quality check abort strobe |
| stop_active | output | 1 | Stop state reached |
| div_tick | output | 1 | Prescaler terminal-count pulse |

## Verification
The teardown and wake-up are driven with the four combinations of stop flavour and self-clock status, and with mixed keep-alive bits. This separates the oscillator, timer, PLL and regulator decisions that each depend on a different subset of the captured mode.

In pseudo stop from self-clock mode, a failing check is followed by a passing one. This tells a controller that retries apart from one that fires only once or never stops retrying.

Stop and wake inputs held or pulsed in the wrong state show whether the sequence is protected. A prescaler interval monitor spanning several stops distinguishes freezing from restarting the dividers.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_SW_OSC,
    ST_PLL_OFF,
    ST_CORE_OFF,
    ST_SYS_OFF,
    ST_STOPPED,
    ST_WK_OSC,
    ST_WK_SYS,
    ST_WK_CORE
  } seq_state_e;

  typedef struct packed {
    logic pseudo;
    logic rti_keep;
    logic wdt_keep;
    logic from_scm;
  } stop_mode_t;

endpackage

// File: rtl/stop_seq_fsm.sv
module stop_seq_fsm
  import stop_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wake_evt,
  input  logic       pstop_sel,
  input  logic       rti_keep,
  input  logic       wdt_keep,
  input  logic       scm_active,
  input  logic       pll_sel_set,
  output seq_state_e state,
  output stop_mode_t mode,
  output logic       pll_sel,
  output logic       accept,
  output logic       exit_now
);

  seq_state_e state_nx;

  assign accept   = (state == ST_RUN) && stop_req;
  assign exit_now = (state == ST_WK_CORE);

  // one step per control-clock cycle; requests outside their state are ignored
  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:      if (stop_req) state_nx = ST_SW_OSC;
      ST_SW_OSC:   state_nx = ST_PLL_OFF;
      ST_PLL_OFF:  state_nx = ST_CORE_OFF;
      ST_CORE_OFF: state_nx = ST_SYS_OFF;
      ST_SYS_OFF:  state_nx = ST_STOPPED;
      ST_STOPPED:  if (wake_evt) state_nx = ST_WK_OSC;
      ST_WK_OSC:   state_nx = ST_WK_SYS;
      ST_WK_SYS:   state_nx = ST_WK_CORE;
      ST_WK_CORE:  state_nx = ST_RUN;
      default:     state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
    end else begin
      state <= state_nx;
    end
  end

  // mode captured once at acceptance, dropped on return to run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (accept) begin
      mode.pseudo   <= pstop_sel;
      mode.rti_keep <= rti_keep;
      mode.wdt_keep <= wdt_keep;
      mode.from_scm <= scm_active;
    end else if (exit_now) begin
      mode <= '0;
    end
  end

  // PLL-select: set by software in run, cleared by the sequencer at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_sel <= 1'b0;
    end else if (accept) begin
      pll_sel <= 1'b0;
    end else if (pll_sel_set && (state == ST_RUN)) begin
      pll_sel <= 1'b1;
    end
  end

  AST_SEL_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_sel) |-> $past(state) == ST_RUN) else $error("pll_sel set outside run"); // R10

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_PLL_OFF) |-> state == ST_CORE_OFF) else $error("teardown skipped"); // R2

endmodule

// File: rtl/stop_gate_dec.sv
module stop_gate_dec
  import stop_seq_pkg::*;
(
  input  seq_state_e state,
  input  stop_mode_t mode,
  output logic       pll_en,
  output logic       osc_en,
  output logic       core_clk_en,
  output logic       sys_clk_en,
  output logic       rti_clk_en,
  output logic       wdt_clk_en,
  output logic       vreg_lp_req,
  output logic       stop_active
);

  logic keep_pll;
  logic stopped;
  logic sys_on;
  logic core_on;

  assign keep_pll = mode.pseudo && mode.from_scm;
  assign stopped  = (state == ST_STOPPED);

  always_comb begin
    unique case (state)
      ST_RUN, ST_SW_OSC, ST_PLL_OFF, ST_CORE_OFF,
      ST_WK_SYS, ST_WK_CORE:                     sys_on = 1'b1;
      default:                                   sys_on = 1'b0;
    endcase
    unique case (state)
      ST_RUN, ST_SW_OSC, ST_PLL_OFF, ST_WK_CORE: core_on = 1'b1;
      default:                                   core_on = 1'b0;
    endcase
  end

  assign pll_en      = (state == ST_RUN) || (state == ST_SW_OSC) || keep_pll;
  assign core_clk_en = core_on;
  assign sys_clk_en  = sys_on;
  assign osc_en      = !stopped || mode.pseudo;
  assign rti_clk_en  = sys_on || (mode.pseudo && mode.rti_keep);
  assign wdt_clk_en  = sys_on || (mode.pseudo && mode.wdt_keep);
  assign vreg_lp_req = stopped && !keep_pll;
  assign stop_active = stopped;

endmodule

// File: rtl/stop_cqc_ctl.sv
module stop_cqc_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic acc_pseudo,
  input  logic acc_scm,
  input  logic exit_now,
  input  logic exit_full_scm,
  input  logic cqc_done,
  input  logic cqc_ok,
  output logic cqc_start,
  output logic cqc_abort
);

  logic pend;
  logic busy;
  logic start_d;

  assign start_d = (exit_now && exit_full_scm) || (pend && !busy && !cqc_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      busy      <= 1'b0;
      cqc_start <= 1'b0;
      cqc_abort <= 1'b0;
    end else begin
      cqc_abort <= accept && acc_scm && !acc_pseudo;
      cqc_start <= start_d;
      if (accept) begin
        pend <= acc_pseudo && acc_scm;
        busy <= 1'b0;
      end else begin
        if (exit_now) begin
          pend <= 1'b0;
        end else if (busy && cqc_done && cqc_ok) begin
          pend <= 1'b0;
        end
        if (start_d) begin
          busy <= 1'b1;
        end else if (cqc_done) begin
          busy <= 1'b0;
        end
      end
    end
  end

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cqc_abort |=> !cqc_abort) else $error("abort wider than one cycle"); // R9

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cqc_start |=> !cqc_start) else $error("start wider than one cycle"); // R8

endmodule

// File: rtl/stop_div_frz.sv
module stop_div_frz #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == LAST);

  // counts only with the system clock; stop holds the phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt)) else $error("prescaler moved while gated"); // R6

endmodule

// File: rtl/stop_clk_seq.sv
module stop_clk_seq
  import stop_seq_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake_evt,
  input  logic pstop_sel,
  input  logic rti_keep,
  input  logic wdt_keep,
  input  logic pll_sel_set,
  input  logic scm_active,
  input  logic cqc_done,
  input  logic cqc_ok,
  output logic pll_sel,
  output logic pll_en,
  output logic osc_en,
  output logic core_clk_en,
  output logic sys_clk_en,
  output logic rti_clk_en,
  output logic wdt_clk_en,
  output logic vreg_lp_req,
  output logic cqc_start,
  output logic cqc_abort,
  output logic stop_active,
  output logic div_tick
);

  seq_state_e state;
  stop_mode_t mode;
  logic       accept;
  logic       exit_now;
  logic       exit_full_scm;

  stop_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .wake_evt    (wake_evt),
    .pstop_sel   (pstop_sel),
    .rti_keep    (rti_keep),
    .wdt_keep    (wdt_keep),
    .scm_active  (scm_active),
    .pll_sel_set (pll_sel_set),
    .state       (state),
    .mode        (mode),
    .pll_sel     (pll_sel),
    .accept      (accept),
    .exit_now    (exit_now)
  );

  stop_gate_dec u_dec (
    .state       (state),
    .mode        (mode),
    .pll_en      (pll_en),
    .osc_en      (osc_en),
    .core_clk_en (core_clk_en),
    .sys_clk_en  (sys_clk_en),
    .rti_clk_en  (rti_clk_en),
    .wdt_clk_en  (wdt_clk_en),
    .vreg_lp_req (vreg_lp_req),
    .stop_active (stop_active)
  );

  assign exit_full_scm = mode.from_scm && !mode.pseudo;

  stop_cqc_ctl u_cqc (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .acc_pseudo    (pstop_sel),
    .acc_scm       (scm_active),
    .exit_now      (exit_now),
    .exit_full_scm (exit_full_scm),
    .cqc_done      (cqc_done),
    .cqc_ok        (cqc_ok),
    .cqc_start     (cqc_start),
    .cqc_abort     (cqc_abort)
  );

  stop_div_frz #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sys_clk_en),
    .tick  (div_tick)
  );

  AST_CORE_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> !pll_sel) else $error("core gated with PLL selected"); // R1

  AST_SYS_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_clk_en) |-> !core_clk_en) else $error("system gated before core"); // R2

  AST_STOP_ONLY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_active) |-> $past(!sys_clk_en && !core_clk_en)) else $error("stop before clocks off"); // R3

  AST_LP_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_lp_req |-> stop_active) else $error("low-power request outside stop"); // R7

  AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> (sys_clk_en && osc_en)) else $error("core woke first"); // R10

endmodule

// File: tb/stop_clk_seq_test.sv
`timescale 1ns/1ps
module stop_clk_seq_test;

  localparam int DIVB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, wake_evt = 0, pstop_sel = 0, rti_keep = 0, wdt_keep = 0;
  logic pll_sel_set = 0, scm_active = 0, cqc_done = 0, cqc_ok = 0;
  logic pll_sel, pll_en, osc_en, core_clk_en, sys_clk_en, rti_clk_en, wdt_clk_en;
  logic vreg_lp_req, cqc_start, cqc_abort, stop_active, div_tick;

  int checks = 0;
  int errors = 0;
  int since = 0;
  int div_seen = 0;
  int div_bad = 0;

  always #2.5 clk = ~clk;

  stop_clk_seq #(.DIV(DIVB)) uut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_evt(wake_evt),
    .pstop_sel(pstop_sel), .rti_keep(rti_keep), .wdt_keep(wdt_keep),
    .pll_sel_set(pll_sel_set), .scm_active(scm_active), .cqc_done(cqc_done),
    .cqc_ok(cqc_ok), .pll_sel(pll_sel), .pll_en(pll_en), .osc_en(osc_en),
    .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .rti_clk_en(rti_clk_en),
    .wdt_clk_en(wdt_clk_en), .vreg_lp_req(vreg_lp_req), .cqc_start(cqc_start),
    .cqc_abort(cqc_abort), .stop_active(stop_active), .div_tick(div_tick)
  );

  // R6 interval monitor: system-enabled cycles between prescaler ticks
  always @(negedge clk) begin
    if (rst_n) begin
      if (sys_clk_en) since = since + 1;
      if (div_tick) begin
        div_seen = div_seen + 1;
        if (since != DIVB) div_bad = div_bad + 1;
        since = 0;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_pll();
    pll_sel_set = 1; step(); pll_sel_set = 0;
    chk("R1 pll_sel set before stop", pll_sel, 1);
  endtask

  task automatic do_stop(input bit ps, input bit rk, input bit wk, input bit scm);
    bit keep;
    keep = ps && scm;
    pstop_sel = ps; rti_keep = rk; wdt_keep = wk; scm_active = scm;
    stop_req = 1; step(); stop_req = 0;
    chk("R1 pll_sel cleared", pll_sel, 0);
    chk("R1 pll_en still on", pll_en, 1);
    chk("R1 core still on", core_clk_en, 1);
    chk("R9 abort strobe", cqc_abort, int'(scm && !ps));
    step();
    chk("R2 pll_en after switch", pll_en, int'(keep));
    chk("R2 core kept one more cycle", core_clk_en, 1);
    chk("R9 abort one cycle", cqc_abort, 0);
    step();
    chk("R2 core gated", core_clk_en, 0);
    chk("R2 sys still on", sys_clk_en, 1);
    chk("R3 not yet stopped", stop_active, 0);
    step();
    chk("R2 sys gated", sys_clk_en, 0);
    chk("R3 stop waits for last gate", stop_active, 0);
    chk("R5 rti gate", rti_clk_en, int'(ps && rk));
    chk("R5 wdt gate", wdt_clk_en, int'(ps && wk));
    step();
    chk("R3 stop active", stop_active, 1);
    chk("R4 oscillator", osc_en, int'(ps));
    chk("R7 low-power request", vreg_lp_req, int'(!keep));
    chk("R2 pll_en in stop", pll_en, int'(keep));
  endtask

  task automatic do_wake(input bit ps, input bit scm);
    bit keep;
    keep = ps && scm;
    wake_evt = 1; step(); wake_evt = 0;
    chk("R10 stop drops", stop_active, 0);
    chk("R10 osc first", osc_en, 1);
    chk("R10 sys still off", sys_clk_en, 0);
    chk("R7 lp request released", vreg_lp_req, 0);
    step();
    chk("R10 sys on", sys_clk_en, 1);
    chk("R10 core still off", core_clk_en, 0);
    chk("R5 rti restored", rti_clk_en, 1);
    chk("R5 wdt restored", wdt_clk_en, 1);
    step();
    chk("R10 core on", core_clk_en, 1);
    chk("R10 pll before run", pll_en, int'(keep));
    step();
    chk("R10 pll on in run", pll_en, 1);
    chk("R10 pll_sel stays clear", pll_sel, 0);
    chk("R9 exit check start", cqc_start, int'(scm && !ps));
  endtask

  task automatic t_reset();
    chk("R12 core", core_clk_en, 1);
    chk("R12 sys", sys_clk_en, 1);
    chk("R12 pll_en", pll_en, 1);
    chk("R12 osc", osc_en, 1);
    chk("R12 rti", rti_clk_en, 1);
    chk("R12 wdt", wdt_clk_en, 1);
    chk("R12 pll_sel", pll_sel, 0);
    chk("R12 stop_active", stop_active, 0);
    chk("R12 lp", vreg_lp_req, 0);
    chk("R12 strobes", int'(cqc_start) + int'(cqc_abort), 0);
  endtask

  task automatic t_full_stop();
    set_pll();
    do_stop(0, 1, 1, 0);
    repeat (7) step();
    chk("R3 stays stopped", stop_active, 1);
    chk("R4 osc off in full stop", osc_en, 0);
    do_wake(0, 0);
  endtask

  task automatic t_pseudo_stop();
    set_pll();
    do_stop(1, 1, 0, 0);
    repeat (3) step();
    do_wake(1, 0);
    do_stop(1, 0, 1, 0);
    repeat (6) step();
    do_wake(1, 0);
  endtask

  task automatic t_pseudo_scm();
    int n;
    do_stop(1, 0, 0, 1);
    step();
    cqc_done = 1; cqc_ok = 0; step(); cqc_done = 0;
    n = 0;
    for (int i = 0; i < 4; i++) begin n += int'(cqc_start); step(); end
    chk("R8 retry after failed check", n, 1);
    cqc_done = 1; cqc_ok = 1; step(); cqc_done = 0; cqc_ok = 0;
    n = 0;
    for (int i = 0; i < 6; i++) begin n += int'(cqc_start); step(); end
    chk("R8 no retry after pass", n, 0);
    chk("R8 pll kept on", pll_en, 1);
    chk("R7 no lp request", vreg_lp_req, 0);
    do_wake(1, 1);
  endtask

  task automatic t_full_scm();
    do_stop(0, 0, 0, 1);
    repeat (4) step();
    do_wake(0, 1);
    cqc_done = 1; cqc_ok = 1; step(); cqc_done = 0; cqc_ok = 0;
    scm_active = 0;
  endtask

  task automatic t_ignore();
    wake_evt = 1; step(); wake_evt = 0;
    chk("R11 wake in run ignored core", core_clk_en, 1);
    chk("R11 wake in run ignored stop", stop_active, 0);
    step();
    chk("R11 wake in run ignored sys", sys_clk_en, 1);
    pstop_sel = 0; scm_active = 0;
    stop_req = 1; step();
    step();
    wake_evt = 1; step(); wake_evt = 0;
    chk("R11 core gated despite wake", core_clk_en, 0);
    step();
    step();
    chk("R11 reached stop despite wake", stop_active, 1);
    repeat (3) step();
    chk("R11 stop held with repeated request", stop_active, 1);
    stop_req = 0;
    do_wake(0, 0);
  endtask

  task automatic t_divider();
    repeat (13) step();
    chk("R6 ticks observed", int'(div_seen > 10), 1);
    chk("R6 phase kept across stops", div_bad, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_full_stop();
    t_pseudo_stop();
    t_pseudo_scm();
    t_full_scm();
    t_ignore();
    t_divider();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule